// File: doc/BRIEF.md
# Dual-Mode PWM Timer Channel

This block is a single up-counting timer channel with four compare registers, numbered 0 to 3, and four output pins. Each compare register has a small action field that says what an equality match against the counter does to the pin that register drives. One register can be chosen to clear the counter, and that register's value then sets the PWM period. The channel runs in one of two PWM schemes. In the paired scheme, registers 0 and 1 together shape pin 0, and registers 2 and 3 together shape pin 2. In the shared-cycle scheme, the clearing register is the period and every other register sets the duty of its own pin.

Software writes the compare registers and the action word through a simple write port. It then selects the scheme, the clear source and the enable. A three-state run machine controls the channel. `ST_OFF` holds the counter at zero and the pins at their initial levels. `ST_PAIRED` and `ST_SHARED` run the two schemes. The transitions are *start* (`ST_OFF` to a run state when the enable rises, with the state chosen by the mode input), *stop* (any run state to `ST_OFF` when the enable falls) and *switch* (between the two run states when the mode input changes). Every transition restarts the counter and reloads the pin initial levels.

A duty register equal to its period register gives a constant pin. With a suitable initial level, the duty can therefore be set anywhere from 0% to 100%.

Top module: `pwm_timer_ch`

## Requirements
- R1: After reset the counter reads 0, all pins are low, and all compare registers and action fields are 0.
- R2: While running, the counter rises by one each clock. When clearing is enabled and the counter equals the selected register, the counter reads 0 on the following clock, so the period is that register's value plus one.
- R3: Writing address 0..3 loads compare register 0..3, and writing address 4 loads the action word. In the action word, field i occupies bits [4i+3:4i]: bit 3 is the initial level (0 low, 1 high), bit 2 is ignored, and bits 1:0 select the match action (00 keep, 01 drive low, 10 drive high, 11 toggle). A pin changes on the clock after the cycle in which the counter equals its register.
- R4: In shared-cycle mode, pin i follows the matches of register i. The pin of the period register stays at its initial level.
- R5: In shared-cycle mode, when the counter is cleared by the period match, every pin returns to its initial level on that same clock.
- R6: In shared-cycle mode, a duty register equal to the period register causes no pin change at its match. With initial high this gives 100% duty, and with initial low it gives 0%.
- R7: In paired mode, matches of registers 0 and 1 act on pin 0, matches of registers 2 and 3 act on pin 2, and pins 1 and 3 are held low.
- R8: In paired mode, when both registers of a pair hold the same value, their common match leaves the pin unchanged.
- R9: In paired mode, the initial level of pin 0 comes from field 0 and the initial level of pin 2 comes from field 2.
- R10: On the clock that sees the enable low, the counter becomes 0 and the pins take their initial levels for the selected mode.
- R11: A change of the mode input while running restarts the counter at 0 and loads the initial levels of the new mode on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable |
| mode_i | input | 1 | Scheme select: 0 paired, 1 shared-cycle |
| clr_en_i | input | 1 | Enables clearing the counter on a compare match |
| clr_sel_i | input | 2 | Register whose match clears the counter (the period register) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0..3 compare registers, 4 action word |
| wr_data_i | input | CNT_W | Write data |
| cnt_o | output | CNT_W | Current counter value |
| pin_o | output | 4 | PWM output pins |

## Verification
The hardest case to reach is a match that coincides with a clear or with its partner register. Here the suppression rule must win over the action field, and a wrong priority only shows as a pin that is constant where it should pulse, or the reverse. The vector table sets duty registers equal to the period register and pair registers equal to each other. For each case it runs past two full periods, then counts the high cycles over exactly one period, so the result does not depend on phase. Directed steps then switch the mode and drop the enable in the middle of a period, and they check the counter and the pin levels on the very next cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int NCMP  = 4;            // compare registers / pins
    localparam int FLD_W = 3;            // stored bits per action field
    localparam int CTL_W = NCMP * FLD_W;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_PAIRED = 2'd1,
        ST_SHARED = 2'd2
    } run_st_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    function automatic logic apply_act(input logic cur, input logic [1:0] act);
        logic r;
        unique case (act_e'(act))
            ACT_KEEP: r = cur;
            ACT_LOW:  r = 1'b0;
            ACT_HIGH: r = 1'b1;
            ACT_TOG:  r = ~cur;
            default:  r = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank #(
    parameter int CNT_W = 16,
    parameter int NCMP  = 4,
    parameter int AW    = 3,
    localparam int SELW = $clog2(NCMP)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic [CNT_W-1:0]      cnt,
    input  logic [SELW-1:0]       per_sel,
    output logic [NCMP*CNT_W-1:0] cmp_flat,
    output logic [NCMP-1:0]       match,
    output logic [NCMP-1:0]       eq_per
);

    logic [CNT_W-1:0] per_val;
    assign per_val = cmp_flat[per_sel*CNT_W +: CNT_W];

    for (genvar g = 0; g < NCMP; g++) begin : g_reg
        logic [CNT_W-1:0] val;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                val <= '0;
            else if (wr_en && (wr_addr == AW'(g)))
                val <= wr_data;
        end
        assign cmp_flat[g*CNT_W +: CNT_W] = val;
        assign match[g]  = (cnt == val);
        assign eq_per[g] = (val == per_val);
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             clr_hit,
    output logic [CNT_W-1:0] cnt
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || clr_hit)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/pwm_pin_ctl.sv
module pwm_pin_ctl
    import pwm_timer_pkg::*;
#(
    parameter int NPIN  = 4,
    localparam int SELW = $clog2(NPIN)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_init,
    input  logic                  init_shared,
    input  logic                  run_shared,
    input  logic                  clr_hit,
    input  logic [SELW-1:0]       per_sel,
    input  logic [NPIN-1:0]       match,
    input  logic [NPIN-1:0]       eq_per,
    input  logic [NPIN*FLD_W-1:0] ctl,
    output logic [NPIN-1:0]       pin
);

    logic [NPIN-1:0] init_sh, init_pr, nxt_sh, nxt_pr;

    // shared-cycle scheme: one pin per register
    for (genvar g = 0; g < NPIN; g++) begin : g_sh
        logic [1:0] act;
        assign act        = ctl[g*FLD_W +: 2];
        assign init_sh[g] = ctl[g*FLD_W + 2];
        always_comb begin
            if (per_sel == SELW'(g))
                nxt_sh[g] = init_sh[g];
            else if (clr_hit)
                nxt_sh[g] = init_sh[g];
            else if (match[g] && !eq_per[g])
                nxt_sh[g] = apply_act(pin[g], act);
            else
                nxt_sh[g] = pin[g];
        end
    end

    // paired scheme: lead/trail registers share the lead pin
    for (genvar p = 0; p < NPIN/2; p++) begin : g_pr
        localparam int LD = 2*p;
        localparam int TR = 2*p + 1;
        assign init_pr[LD] = ctl[LD*FLD_W + 2];
        assign init_pr[TR] = 1'b0;
        assign nxt_pr[TR]  = 1'b0;
        always_comb begin
            if (match[LD] && match[TR])
                nxt_pr[LD] = pin[LD];
            else if (match[LD])
                nxt_pr[LD] = apply_act(pin[LD], ctl[LD*FLD_W +: 2]);
            else if (match[TR])
                nxt_pr[LD] = apply_act(pin[LD], ctl[TR*FLD_W +: 2]);
            else
                nxt_pr[LD] = pin[LD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pin <= '0;
        else if (load_init)
            pin <= init_shared ? init_sh : init_pr;
        else if (run_shared)
            pin <= nxt_sh;
        else
            pin <= nxt_pr;
    end

endmodule

// File: rtl/pwm_timer_ch.sv
module pwm_timer_ch
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int AW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             mode_i,
    input  logic             clr_en_i,
    input  logic [1:0]       clr_sel_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [CNT_W-1:0] wr_data_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [NCMP-1:0]  pin_o
);

    localparam int CTL_ADDR = NCMP;

    run_st_e st, st_nxt;
    logic    restart, run_shared, clr_hit;

    logic [NCMP*CNT_W-1:0] cmp_flat;
    logic [NCMP-1:0]       match, eq_per;
    logic [CTL_W-1:0]      ctl;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nxt;
    end

    // next state: start / stop / switch
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_OFF:    if (en_i) st_nxt = mode_i ? ST_SHARED : ST_PAIRED;
            ST_PAIRED: if (!en_i) st_nxt = ST_OFF;
                       else if (mode_i) st_nxt = ST_SHARED;
            ST_SHARED: if (!en_i) st_nxt = ST_OFF;
                       else if (!mode_i) st_nxt = ST_PAIRED;
            default:   st_nxt = ST_OFF;
        endcase
    end

    // state-derived controls
    always_comb begin
        restart    = (st == ST_OFF) || (st_nxt != st);
        run_shared = (st == ST_SHARED);
        clr_hit    = clr_en_i && match[clr_sel_i];
    end

    // action word: keep initial level and action bits of each field
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_en_i && (wr_addr_i == AW'(CTL_ADDR)))
            for (int i = 0; i < NCMP; i++)
                ctl[i*FLD_W +: FLD_W] <= {wr_data_i[i*4+3], wr_data_i[i*4 +: 2]};
    end

    pwm_cmp_bank #(.CNT_W(CNT_W), .NCMP(NCMP), .AW(AW)) cmp_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
        .cnt(cnt_o), .per_sel(clr_sel_i),
        .cmp_flat(cmp_flat), .match(match), .eq_per(eq_per)
    );

    pwm_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n),
        .restart(restart), .clr_hit(clr_hit), .cnt(cnt_o)
    );

    pwm_pin_ctl #(.NPIN(NCMP)) pin_i (
        .clk(clk), .rst_n(rst_n),
        .load_init(restart), .init_shared(mode_i), .run_shared(run_shared),
        .clr_hit(clr_hit), .per_sel(clr_sel_i),
        .match(match), .eq_per(eq_per), .ctl(ctl), .pin(pin_o)
    );

endmodule

// File: rtl/pwm_timer_ch_chk.sv
module pwm_timer_ch_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  en_i,
    input logic                  mode_i,
    input logic                  clr_en_i,
    input logic [1:0]            clr_sel_i,
    input logic [1:0]            st,
    input logic [CNT_W-1:0]      cnt_o,
    input logic [3:0]            pin_o,
    input logic [4*CNT_W-1:0]    cmp_flat,
    input logic [3:0]            init_bits
);

    logic             stay, per_hit;
    logic [CNT_W-1:0] reg_a, reg_b, reg_p;
    logic [3:0]       init_pr, init_mode;

    assign reg_a     = cmp_flat[0 +: CNT_W];
    assign reg_b     = cmp_flat[CNT_W +: CNT_W];
    assign reg_p     = cmp_flat[clr_sel_i*CNT_W +: CNT_W];
    assign stay      = en_i && (((st == ST_PAIRED) && !mode_i) || ((st == ST_SHARED) && mode_i));
    assign per_hit   = clr_en_i && (cnt_o == reg_p);
    assign init_pr   = {1'b0, init_bits[2], 1'b0, init_bits[0]};
    assign init_mode = mode_i ? init_bits : init_pr;

    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stay && !per_hit) |=> (cnt_o == CNT_W'($past(cnt_o) + 1'b1)))
        else $error("counter did not step");

    assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stay && per_hit) |=> (cnt_o == '0))
        else $error("counter did not wrap at period");

    assert_off_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_OFF) |-> (cnt_o == '0))
        else $error("counter moving while off");

    assert_stop_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st != ST_OFF) && !en_i) |=> (pin_o == $past(init_mode)))
        else $error("pins not at initial level after stop");

    assert_pair_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PAIRED) |-> (!pin_o[1] && !pin_o[3]))
        else $error("unused paired pins not low");

    assert_pair_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stay && (st == ST_PAIRED) && (cnt_o == reg_a) && (reg_a == reg_b)) |=> $stable(pin_o[0]))
        else $error("equal pair changed pin");

    assert_shared_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stay && (st == ST_SHARED) && per_hit) |=> (pin_o == $past(init_bits)))
        else $error("pins not reset at period");

endmodule

bind pwm_timer_ch pwm_timer_ch_chk #(.CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
    .clr_en_i(clr_en_i), .clr_sel_i(clr_sel_i), .st(st),
    .cnt_o(cnt_o), .pin_o(pin_o), .cmp_flat(cmp_flat),
    .init_bits({ctl[11], ctl[8], ctl[5], ctl[2]})
);

// File: tb/pwm_timer_ch_tb.sv
module pwm_timer_ch_tb_top;

    typedef struct packed {
        logic        mode;
        logic [1:0]  sel;
        logic [15:0] a, b, c, d, ctl;
        logic [1:0]  pin;
        logic [15:0] per;
        logic [15:0] exp_hi;
        logic [3:0]  req;
    } vec_t;

    // high cycles of one pin over exactly one period
    localparam vec_t VT [9] = '{
        '{1'b1, 2'd0, 16'd9, 16'd3, 16'd0, 16'd0, 16'h0090, 2'd1, 16'd9,  16'd4,  4'd4},  // R4 duty 4/10
        '{1'b1, 2'd0, 16'd9, 16'd0, 16'd9, 16'd0, 16'h0900, 2'd2, 16'd9,  16'd10, 4'd6},  // R6 100%
        '{1'b1, 2'd0, 16'd9, 16'd0, 16'd0, 16'd9, 16'h2000, 2'd3, 16'd9,  16'd0,  4'd6},  // R6 0%
        '{1'b1, 2'd3, 16'd5, 16'd0, 16'd0, 16'd7, 16'h0002, 2'd0, 16'd7,  16'd2,  4'd5},  // R5 period on reg 3
        '{1'b0, 2'd0, 16'd9, 16'd4, 16'd0, 16'd0, 16'h0012, 2'd0, 16'd9,  16'd5,  4'd7},  // R7 pair 0/1
        '{1'b0, 2'd0, 16'd9, 16'd0, 16'd6, 16'd6, 16'h1A00, 2'd2, 16'd9,  16'd10, 4'd8},  // R8 equal pair
        '{1'b0, 2'd1, 16'd2, 16'd11,16'd0, 16'd0, 16'h0012, 2'd0, 16'd11, 16'd9,  4'd7},  // R7 period on reg 1
        '{1'b1, 2'd0, 16'd9, 16'd4, 16'd0, 16'd0, 16'h0030, 2'd1, 16'd9,  16'd5,  4'd3},  // R3 toggle
        '{1'b1, 2'd0, 16'd5, 16'd0, 16'd0, 16'd0, 16'h0009, 2'd0, 16'd5,  16'd6,  4'd4}   // R4 period pin held
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0, mode = 1'b0, clr_en = 1'b0, wr_en = 1'b0;
    logic [1:0]  clr_sel = 2'd0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] cnt_o;
    logic [3:0]  pin_o;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    pwm_timer_ch dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode),
        .clr_en_i(clr_en), .clr_sel_i(clr_sel),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .cnt_o(cnt_o), .pin_o(pin_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input logic m, input logic [1:0] s, input logic [15:0] a,
                         input logic [15:0] b, input logic [15:0] c,
                         input logic [15:0] d, input logic [15:0] ctl);
        @(negedge clk); en = 1'b0;
        wr(3'd0, a); wr(3'd1, b); wr(3'd2, c); wr(3'd3, d); wr(3'd4, ctl);
        mode = m; clr_sel = s; clr_en = 1'b1;
        @(negedge clk); en = 1'b1;
    endtask

    task automatic run_vec(input vec_t v);
        int hi;
        setup(v.mode, v.sel, v.a, v.b, v.c, v.d, v.ctl);
        repeat (2*(int'(v.per)+1) + 4) @(negedge clk);
        hi = 0;
        for (int n = 0; n <= int'(v.per); n++) begin
            @(negedge clk);
            hi += int'(pin_o[v.pin]);
        end
        chk($sformatf("R%0d vector high-count", v.req), hi, int'(v.exp_hi));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int found;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 counter", int'(cnt_o), 0);
        chk("R1 pins", int'(pin_o), 0);

        for (int k = 0; k < 9; k++) run_vec(VT[k]);

        // R2 step and wrap at period value 5
        setup(1'b1, 2'd0, 16'd5, 16'd0, 16'd0, 16'd0, 16'h0000);
        found = 0;
        for (int n = 0; n < 20 && found == 0; n++) begin
            @(negedge clk);
            if (cnt_o == 16'd4) found = 1;
        end
        chk("R2 reached 4", found, 1);
        @(negedge clk);
        chk("R2 step to 5", int'(cnt_o), 5);
        @(negedge clk);
        chk("R2 wrap to 0", int'(cnt_o), 0);

        // R10 stop loads shared initial levels
        wr(3'd4, 16'h8888);
        @(negedge clk); en = 1'b0;
        @(negedge clk);
        chk("R10 counter after stop", int'(cnt_o), 0);
        chk("R10 pins after stop", int'(pin_o), 15);

        // R11 / R9 switch from shared to paired mid-period
        setup(1'b1, 2'd0, 16'd5, 16'd0, 16'd0, 16'd0, 16'h8008);
        repeat (10) @(negedge clk);
        chk("R4 shared pins hold initial", int'(pin_o), 9);
        mode = 1'b0;
        @(negedge clk);
        chk("R11 counter restart", int'(cnt_o), 0);
        chk("R9 paired initial pins", int'(pin_o), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule